// File: doc/BRIEF.md
# Traffic Address Pattern Generator

This block supplies the start address and the transaction ID for every transaction of one traffic command. A command is set up by a single load strobe that captures a base address, a start offset, an upper address limit, a step value, a random seed, a pattern selector, the burst shape (size, length, type) and the ID settings. Each later request pulse yields one address and one ID on the following cycle.

Four patterns are supported. Two walk an address cursor upward from base plus offset: one steps by the byte count of the burst, the other by a programmed step. When the cursor reaches the upper limit, it reloads the base. The other two draw addresses from a 48-bit maximal-length LFSR and fold them into the window above the base. One of them also aligns the result to the burst size. The ID either stays fixed or counts up once per transaction.

Top module: `addrPatternGen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `addrValid`, `addrOut` and `idOut` are all zero.
- R2: A `nextReq` pulse before the first `loadCfg` since reset produces no `addrValid`.
- R3: After a load, a `nextReq` pulse in cycle t raises `addrValid` in cycle t+1 only, with that transaction's address and ID on `addrOut` and `idOut`. Without a request, `addrValid` is low.
- R4: When `loadCfg` and `nextReq` are high in the same cycle, the load is taken and the request is dropped. No `addrValid` follows, and the first request after that returns the first address of the new command.
- R5: In patterns 2'b00 and 2'b01 the first transaction address is `cfgBase + cfgOffset`, taken modulo 2^48.
- R6: In pattern 2'b00 the step is 2^size when `cfgBurst` is 2'b00 (fixed). For any other burst type it is 2^size*(len+1).
- R7: In pattern 2'b01 the step is `cfgStep`.
- R8: In patterns 2'b00 and 2'b01, the cursor plus the step is computed without truncation. When that sum is greater than or equal to `cfgHigh`, the next address is `cfgBase`. Otherwise it is the sum.
- R9: In patterns 2'b10 and 2'b11 the address is `cfgBase + (L & W)`. L is the LFSR state. W is 2^k-1, where 2^k is the largest power of two not above `cfgHigh - cfgBase`, and W is 0 when `cfgHigh <= cfgBase`. L starts at the seed and, after each accepted request in any pattern, shifts left by one with the XOR of bits 47, 46, 20 and 19 entering bit 0. The offset is ignored in these patterns.
- R10: In pattern 2'b11 the low `cfgSize` bits of `L & W` are also cleared, so the address minus the base is a multiple of 2^size.
- R11: A zero seed is replaced by 1, and the LFSR state is never zero.
- R12: With `cfgIdIncr` = 0 every transaction carries `cfgIdStart`. With `cfgIdIncr` = 1 the IDs are `cfgIdStart`, +1, +2, and so on, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadCfg | input | 1 | Captures the configuration and starts a command |
| nextReq | input | 1 | Requests the next transaction address |
| cfgBase | input | 48 | Base address, and the reload target at wrap |
| cfgOffset | input | 48 | Offset of the first address above the base |
| cfgHigh | input | 48 | Upper address limit |
| cfgStep | input | 48 | Step used in pattern 2'b01 |
| cfgSeed | input | 48 | LFSR seed |
| cfgPattern | input | 2 | 00 burst step, 01 fixed step, 10 random, 11 random aligned |
| cfgSize | input | 3 | Burst size exponent |
| cfgLen | input | 8 | Burst length minus one |
| cfgBurst | input | 2 | Burst type, 00 fixed |
| cfgIdIncr | input | 1 | 1 makes the ID count up per transaction |
| cfgIdStart | input | 16 | First transaction ID |
| addrValid | output | 1 | One-cycle strobe qualifying addrOut and idOut |
| addrOut | output | 48 | Transaction start address |
| idOut | output | 16 | Transaction ID |

## Verification
A new command load and an address request can arrive in the same cycle. The bench raises both strobes on one edge, mid-command, right after another command has issued several transactions. It then expects `addrValid` to stay low and the next lone request to return the new command's first address and starting ID. A second collision happens inside the datapath: the cursor reload at the upper limit falls in the same cycle as an ID wrap from 16'hFFFF. The bench arranges these two to coincide, and its reference model judges both values on that cycle.

// File: rtl/apgPkg.sv
package apgPkg;

  typedef enum logic [1:0] {
    PAT_BURST_STEP = 2'b00,
    PAT_FIXED_STEP = 2'b01,
    PAT_RANDOM     = 2'b10,
    PAT_RAND_ALIGN = 2'b11
  } patMode_e;

  localparam logic [1:0] BURST_FIXED = 2'b00;

  typedef struct packed {
    logic loadCfg;
    logic advance;
  } apgStrobe_t;

endpackage

// File: rtl/apgLfsr.sv
module apgLfsr #(
  parameter int WIDTH = 48,
  parameter logic [WIDTH-1:0] TAP_MASK = 48'hC000_0018_0000,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seedLoad,
  input  logic [WIDTH-1:0] seedIn,
  input  logic             stepEn,
  output logic [WIDTH-1:0] state
);

  logic feedback;
  logic [WIDTH-1:0] seedSafe;

  always_comb begin
    feedback = ^(state & TAP_MASK);
    seedSafe = (seedIn == '0) ? DEFAULT_SEED : seedIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= DEFAULT_SEED;
    end else if (seedLoad) begin
      state <= seedSafe;
    end else if (stepEn) begin
      state <= {state[WIDTH-2:0], feedback};
    end
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    state != '0); // R11

endmodule

// File: rtl/apgControl.sv
module apgControl import apgPkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadReq,
  input  logic       nextReq,
  output apgStrobe_t strobe,
  output logic       addrValid
);

  logic cfgLoaded;

  always_comb begin
    strobe.loadCfg = loadReq;
    strobe.advance = nextReq & ~loadReq & cfgLoaded;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLoaded <= 1'b0;
      addrValid <= 1'b0;
    end else begin
      if (loadReq) begin
        cfgLoaded <= 1'b1;
      end
      addrValid <= strobe.advance;
    end
  end

  AST_VALID_AFTER_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (nextReq && !loadReq && cfgLoaded) |=> addrValid); // R3

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |=> !addrValid); // R4

  AST_NO_VALID_UNLOADED: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoaded |=> !addrValid); // R2

endmodule

// File: rtl/apgDatapath.sv
module apgDatapath import apgPkg::*; #(
  parameter int ADDR_W = 48,
  parameter int ID_W   = 16,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter logic [ADDR_W-1:0] LFSR_TAPS = 48'hC000_0018_0000,
  parameter logic [ADDR_W-1:0] LFSR_DEFAULT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  apgStrobe_t        strobe,
  input  logic              validIn,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgOffset,
  input  logic [ADDR_W-1:0] cfgHigh,
  input  logic [ADDR_W-1:0] cfgStep,
  input  logic [ADDR_W-1:0] cfgSeed,
  input  logic [1:0]        cfgPattern,
  input  logic [SIZE_W-1:0] cfgSize,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [1:0]        cfgBurst,
  input  logic              cfgIdIncr,
  input  logic [ID_W-1:0]   cfgIdStart,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ID_W-1:0]   idOut
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  // Mask of all bits strictly below the most significant set bit of v.
  function automatic logic [ADDR_W-1:0] belowMsbMask(input logic [ADDR_W-1:0] v);
    logic [ADDR_W-1:0] s;
    s = v;
    for (int sh = 1; sh < ADDR_W; sh = sh * 2) begin
      s = s | (s >> sh);
    end
    return s >> 1;
  endfunction

  // Configuration captured at load
  logic [ADDR_W-1:0] baseR, highR, stepR, winR, keepR, cursorR;
  patMode_e          modeR;
  logic              idIncrR;
  logic [ID_W-1:0]   idCurR;

  // Load-time derivations
  logic [ADDR_W-1:0] sizeUnit, burstStep, loadStep, loadWin;

  always_comb begin
    sizeUnit  = ONE << cfgSize;
    burstStep = (cfgBurst == BURST_FIXED) ? sizeUnit
                                           : ((ADDR_W'(cfgLen) + ONE) << cfgSize);
    loadStep  = (patMode_e'(cfgPattern) == PAT_FIXED_STEP) ? cfgStep : burstStep;
    loadWin   = (cfgHigh > cfgBase) ? belowMsbMask(cfgHigh - cfgBase) : '0;
  end

  // Random address source
  logic [ADDR_W-1:0] lfsrState;

  apgLfsr #(
    .WIDTH       (ADDR_W),
    .TAP_MASK    (LFSR_TAPS),
    .DEFAULT_SEED(LFSR_DEFAULT)
  ) uLfsr (
    .clk     (clk),
    .rstN    (rstN),
    .seedLoad(strobe.loadCfg),
    .seedIn  (cfgSeed),
    .stepEn  (strobe.advance),
    .state   (lfsrState)
  );

  // Address selection and cursor advance
  logic              isRandom;
  logic [ADDR_W-1:0] randOff, curAddr, cursorNext;
  logic [ADDR_W:0]   sumExt;
  logic              wrapHit;

  always_comb begin
    isRandom   = (modeR == PAT_RANDOM) || (modeR == PAT_RAND_ALIGN);
    randOff    = lfsrState & winR & ((modeR == PAT_RAND_ALIGN) ? keepR : '1);
    curAddr    = isRandom ? (baseR + randOff) : cursorR;
    sumExt     = {1'b0, cursorR} + {1'b0, stepR};
    wrapHit    = sumExt >= {1'b0, highR};
    cursorNext = wrapHit ? baseR : sumExt[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR   <= '0;
      highR   <= '0;
      stepR   <= '0;
      winR    <= '0;
      keepR   <= '1;
      cursorR <= '0;
      modeR   <= PAT_BURST_STEP;
      idIncrR <= 1'b0;
      idCurR  <= '0;
      addrOut <= '0;
      idOut   <= '0;
    end else if (strobe.loadCfg) begin
      baseR   <= cfgBase;
      highR   <= cfgHigh;
      stepR   <= loadStep;
      winR    <= loadWin;
      keepR   <= ~(sizeUnit - ONE);
      cursorR <= cfgBase + cfgOffset;
      modeR   <= patMode_e'(cfgPattern);
      idIncrR <= cfgIdIncr;
      idCurR  <= cfgIdStart;
    end else if (strobe.advance) begin
      addrOut <= curAddr;
      idOut   <= idCurR;
      cursorR <= cursorNext;
      if (idIncrR) begin
        idCurR <= idCurR + 1'b1;
      end
    end
  end

  AST_RAND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && (modeR == PAT_RANDOM || modeR == PAT_RAND_ALIGN))
      |-> (addrOut >= baseR) && (addrOut == baseR || addrOut < highR)); // R9

  AST_RAND_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && modeR == PAT_RAND_ALIGN)
      |-> (((addrOut - baseR) & ~keepR) == '0)); // R10

  AST_ID_SEQUENCE: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && $past(validIn))
      |-> (idOut == (idIncrR ? ID_W'($past(idOut) + 1'b1) : $past(idOut)))); // R12

endmodule

// File: rtl/addrPatternGen.sv
module addrPatternGen import apgPkg::*; #(
  parameter int ADDR_W = 48,
  parameter int ID_W   = 16,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter logic [ADDR_W-1:0] LFSR_TAPS = 48'hC000_0018_0000,
  parameter logic [ADDR_W-1:0] LFSR_DEFAULT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadCfg,
  input  logic              nextReq,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgOffset,
  input  logic [ADDR_W-1:0] cfgHigh,
  input  logic [ADDR_W-1:0] cfgStep,
  input  logic [ADDR_W-1:0] cfgSeed,
  input  logic [1:0]        cfgPattern,
  input  logic [SIZE_W-1:0] cfgSize,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [1:0]        cfgBurst,
  input  logic              cfgIdIncr,
  input  logic [ID_W-1:0]   cfgIdStart,
  output logic              addrValid,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ID_W-1:0]   idOut
);

  apgStrobe_t strobe;

  apgControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .loadReq  (loadCfg),
    .nextReq  (nextReq),
    .strobe   (strobe),
    .addrValid(addrValid)
  );

  apgDatapath #(
    .ADDR_W      (ADDR_W),
    .ID_W        (ID_W),
    .LEN_W       (LEN_W),
    .SIZE_W      (SIZE_W),
    .LFSR_TAPS   (LFSR_TAPS),
    .LFSR_DEFAULT(LFSR_DEFAULT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .validIn   (addrValid),
    .cfgBase   (cfgBase),
    .cfgOffset (cfgOffset),
    .cfgHigh   (cfgHigh),
    .cfgStep   (cfgStep),
    .cfgSeed   (cfgSeed),
    .cfgPattern(cfgPattern),
    .cfgSize   (cfgSize),
    .cfgLen    (cfgLen),
    .cfgBurst  (cfgBurst),
    .cfgIdIncr (cfgIdIncr),
    .cfgIdStart(cfgIdStart),
    .addrOut   (addrOut),
    .idOut     (idOut)
  );

endmodule

// File: tb/tb_addrPatternGen.sv
module tb_addrPatternGen;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, loadCfg, nextReq;
  logic [47:0] cfgBase, cfgOffset, cfgHigh, cfgStep, cfgSeed;
  logic [1:0]  cfgPattern, cfgBurst;
  logic [2:0]  cfgSize;
  logic [7:0]  cfgLen;
  logic        cfgIdIncr;
  logic [15:0] cfgIdStart;
  logic        addrValid;
  logic [47:0] addrOut;
  logic [15:0] idOut;

  addrPatternGen dut (
    .clk(clk), .rstN(rstN), .loadCfg(loadCfg), .nextReq(nextReq),
    .cfgBase(cfgBase), .cfgOffset(cfgOffset), .cfgHigh(cfgHigh),
    .cfgStep(cfgStep), .cfgSeed(cfgSeed), .cfgPattern(cfgPattern),
    .cfgSize(cfgSize), .cfgLen(cfgLen), .cfgBurst(cfgBurst),
    .cfgIdIncr(cfgIdIncr), .cfgIdStart(cfgIdStart),
    .addrValid(addrValid), .addrOut(addrOut), .idOut(idOut)
  );

  int    checks = 0;
  int    fails  = 0;
  string curTag = "R3";

  // Reference model state
  bit          mLoaded = 0;
  logic [47:0] mBase, mHigh, mStep, mCursor, mLfsr, mWin;
  logic [1:0]  mMode;
  logic [2:0]  mSize;
  bit          mIdIncr;
  logic [15:0] mId;
  bit          expValid;
  logic [47:0] expAddr;
  logic [15:0] expId;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [47:0] lfsrAdvance(logic [47:0] x);
    return {x[46:0], x[47] ^ x[46] ^ x[20] ^ x[19]};
  endfunction

  function automatic logic [47:0] windowOf(logic [47:0] b, logic [47:0] h);
    logic [47:0] span, w;
    bit found;
    w = '0;
    found = 0;
    if (h > b) begin
      span = h - b;
      for (int i = 47; i >= 0; i--) begin
        if (!found && span[i]) begin
          w = (48'h1 << i) - 48'h1;
          found = 1;
        end
      end
    end
    return w;
  endfunction

  task automatic setCfg(logic [47:0] b, logic [47:0] o, logic [47:0] h, logic [47:0] s,
                        logic [47:0] sd, logic [1:0] p, logic [2:0] sz, logic [7:0] ln,
                        logic [1:0] bt, bit inc, logic [15:0] id0);
    cfgBase = b; cfgOffset = o; cfgHigh = h; cfgStep = s; cfgSeed = sd;
    cfgPattern = p; cfgSize = sz; cfgLen = ln; cfgBurst = bt;
    cfgIdIncr = inc; cfgIdStart = id0;
  endtask

  // Apply one cycle of strobes, predict, clock, and compare
  task automatic step(bit ld, bit nx);
    logic [47:0] off;
    logic [48:0] sum;
    string vtag;
    loadCfg = ld;
    nextReq = nx;
    expValid = 0;
    vtag = !mLoaded ? "R2" : ((ld && nx) ? "R4" : "R3");
    if (ld) begin
      mLoaded = 1;
      mBase = cfgBase; mHigh = cfgHigh; mMode = cfgPattern; mSize = cfgSize;
      mIdIncr = cfgIdIncr; mId = cfgIdStart;
      mCursor = cfgBase + cfgOffset;
      mLfsr = (cfgSeed == 0) ? 48'h1 : cfgSeed;
      if (cfgPattern == 2'b01) mStep = cfgStep;
      else if (cfgBurst == 2'b00) mStep = 48'h1 << cfgSize;
      else mStep = (48'(cfgLen) + 48'h1) << cfgSize;
      mWin = windowOf(cfgBase, cfgHigh);
    end else if (nx && mLoaded) begin
      expValid = 1;
      if (mMode[1]) begin
        off = mLfsr & mWin;
        if (mMode == 2'b11) off = off & ~((48'h1 << mSize) - 48'h1);
        expAddr = mBase + off;
      end else begin
        expAddr = mCursor;
      end
      expId = mId;
      sum = {1'b0, mCursor} + {1'b0, mStep};
      mCursor = (sum >= {1'b0, mHigh}) ? mBase : sum[47:0];
      mLfsr = lfsrAdvance(mLfsr);
      if (mIdIncr) mId = mId + 16'h1;
    end
    @(posedge clk);
    #2;
    loadCfg = 0;
    nextReq = 0;
    check(vtag, "addrValid", 64'(addrValid), 64'(expValid));
    if (expValid) begin
      check(curTag, "addrOut", 64'(addrOut), 64'(expAddr));
      check(curTag, "idOut", 64'(idOut), 64'(expId));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 0; loadCfg = 0; nextReq = 0;
    setCfg(0, 0, 0, 0, 0, 2'b00, 3'd0, 8'd0, 2'b00, 1'b0, 16'h0);
    repeat (3) @(posedge clk);
    #2;
    check("R1", "addrValid", 64'(addrValid), 64'h0);
    check("R1", "addrOut", 64'(addrOut), 64'h0);
    check("R1", "idOut", 64'(idOut), 64'h0);
    rstN = 1;
    @(posedge clk);
    #2;
    check("R1", "addrValid after release", 64'(addrValid), 64'h0);

    // R2: requests before any load
    step(0, 1);
    step(0, 1);

    // R5 R6 R8 R12: INCR size 2 len 3 -> step 16, wrap at 0x1080, ID wraps at FFFF
    curTag = "R5 R6 R8 R12";
    setCfg(48'h1000, 48'h20, 48'h1080, 48'h0, 48'h0, 2'b00, 3'd2, 8'd3, 2'b01, 1'b1, 16'hFFFA);
    step(1, 0);
    for (int i = 0; i < 12; i++) step(0, 1);

    // R6: fixed burst, size 3 -> step 8, constant ID
    curTag = "R6 R12";
    setCfg(48'h400, 48'h0, 48'h420, 48'h0, 48'h0, 2'b00, 3'd3, 8'd7, 2'b00, 1'b0, 16'h1234);
    step(1, 0);
    for (int i = 0; i < 6; i++) begin
      step(0, 1);
      step(0, 0);
    end

    // R6: wrap burst type, size 0 len 1 -> step 2
    curTag = "R6";
    setCfg(48'h10, 48'h3, 48'h1A, 48'h0, 48'h0, 2'b00, 3'd0, 8'd1, 2'b10, 1'b1, 16'h7);
    step(1, 0);
    for (int i = 0; i < 7; i++) step(0, 1);

    // R7 R8: fixed step near the top of the space; sum carries past 48 bits
    curTag = "R7 R8";
    setCfg(48'hFFFF_FFFF_F000, 48'h0, 48'hFFFF_FFFF_FFFF, 48'h800, 48'h0,
           2'b01, 3'd0, 8'd0, 2'b01, 1'b1, 16'h0);
    step(1, 0);
    for (int i = 0; i < 5; i++) step(0, 1);

    // R4: load and request in the same cycle mid-command
    curTag = "R4 R5";
    setCfg(48'h8000, 48'h40, 48'h9000, 48'h100, 48'h0, 2'b01, 3'd0, 8'd0, 2'b01, 1'b1, 16'h55);
    step(1, 1);
    step(0, 1);
    step(0, 1);

    // R9: random pattern, window 0x3FFF above base
    curTag = "R9";
    setCfg(48'h2000, 48'h0, 48'h7000, 48'h0, 48'h1234_5678_9AB,
           2'b10, 3'd0, 8'd0, 2'b01, 1'b1, 16'h100);
    step(1, 0);
    for (int i = 0; i < 40; i++) step(0, 1);

    // R10 R11: aligned random, zero seed replaced by 1
    curTag = "R10 R11";
    setCfg(48'hA000_0000, 48'h0, 48'hA010_0000, 48'h0, 48'h0,
           2'b11, 3'd4, 8'd0, 2'b01, 1'b0, 16'h9);
    step(1, 0);
    for (int i = 0; i < 80; i++) step(0, 1);

    // R9: degenerate window (high not above base) always yields base
    curTag = "R9";
    setCfg(48'h5000, 48'h0, 48'h5000, 48'h0, 48'hFFFF_0000_1111,
           2'b10, 3'd0, 8'd0, 2'b01, 1'b0, 16'h3);
    step(1, 0);
    for (int i = 0; i < 5; i++) step(0, 1);

    // R3: request followed by idle cycles keeps addrValid low
    curTag = "R3";
    step(0, 1);
    step(0, 0);
    step(0, 0);

    summary();
    $finish;
  end

endmodule